// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's cache controller and decides whether a store-conditional may write memory. A load-linked request arms a single reservation. The reservation records the cache-block part of the request address. Coherence traffic seen on the bus can break the reservation: an invalidation or a read-for-ownership aimed at the same block breaks it. Losing the block to a local eviction breaks it as well. When the store-conditional later arrives, the monitor grants the store only if the reservation is still armed. It then reports the outcome to the processor.

The comparison works on whole blocks. The block size is a parameter, and the offset bits inside a block play no part in any match. The store grant is combinational in the cycle of the store-conditional, so the cache can commit the write at once. The pass/fail report to the processor is registered and appears one cycle later. Every store-conditional disarms the reservation, whatever its outcome.

Top module: `resv_monitor`

## Requirements
- R1: After reset, and after any later reset, the reservation is disarmed. While `rstN` is low, `storeGrant`, `scDone` and `scPass` are 0.
- R2: A store-conditional that follows a load-linked, with no breaking event between them, drives `storeGrant`=1 in its own cycle. One cycle later it gives `scDone`=1 and `scPass`=1.
- R3: A store-conditional with no armed reservation gives `storeGrant`=0 in its cycle. One cycle later it gives `scDone`=1 and `scPass`=0.
- R4: A snooped invalidation (`snoopInv`) whose address lies in the reserved block breaks the reservation. With the default 64-byte blocks, address bits [5:0] are ignored.
- R5: A snooped read-for-ownership (`snoopRdx`) whose address lies in the reserved block breaks the reservation.
- R6: Snooped invalidations or read-for-ownership requests to any other block leave the reservation armed.
- R7: An eviction (`evictValid`) of the reserved block breaks the reservation. An eviction of another block does not.
- R8: Every store-conditional disarms the reservation, so a second store-conditional without a new load-linked fails.
- R9: A store-conditional in the same cycle as a breaking event for the reserved block fails. A same-cycle snoop to another block does not make it fail.
- R10: A new load-linked replaces the reserved block. Snoops to the previous block then have no effect.
- R11: A load-linked in the same cycle as a snoop to its own block still arms the reservation. The snoop is ordered before the load.
- R12: `scDone` is 1 only in the cycle after a store-conditional request, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| llValid | input | 1 | Load-linked request this cycle |
| scValid | input | 1 | Store-conditional request this cycle |
| reqAddr | input | ADDR_W | Byte address of the processor request |
| snoopInv | input | 1 | Snooped invalidation this cycle |
| snoopRdx | input | 1 | Snooped read-for-ownership this cycle |
| snoopAddr | input | ADDR_W | Byte address of the snooped transaction |
| evictValid | input | 1 | Local cache is evicting a block this cycle |
| evictAddr | input | ADDR_W | Byte address of the evicted block |
| storeGrant | output | 1 | Store may be performed (same cycle as the store-conditional) |
| scDone | output | 1 | Store-conditional outcome is valid (one cycle later) |
| scPass | output | 1 | Store-conditional succeeded, qualified by `scDone` |

## Verification
The assertions assume the processor never raises `llValid` and `scValid` in the same cycle. This follows from a single in-order memory pipe, which issues one of the two at most. The stimulus table holds one processor operation per row, so it never breaks this assumption. Snoops and evictions may still coincide with either operation. The table uses this freedom on purpose to reach the same-cycle ordering cases.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Strobes issued by the control unit to the address datapath.
  typedef struct packed {
    logic loadTag;    // capture the block tag of reqAddr
    logic compareEn;  // reservation armed, comparators active
  } resvStrobe_t;

  // Block-match results reported back by the datapath.
  typedef struct packed {
    logic invHit;
    logic rdxHit;
    logic evictHit;
  } resvHit_t;

  typedef enum logic {
    RESV_IDLE  = 1'b0,
    RESV_ARMED = 1'b1
  } resvState_t;

  localparam int unsigned NUM_PROBES = 3;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snoopInv,
  input  logic              snoopRdx,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  output resvHit_t          hits
);

  localparam int unsigned OFS_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0]  lockTag;
  logic [ADDR_W-1:0] probeAddr  [NUM_PROBES];
  logic              probeValid [NUM_PROBES];
  logic [NUM_PROBES-1:0] hitVec;

  // Offset bits never take part in a block match.
  logic unusedOfsBits;
  assign unusedOfsBits = ^{reqAddr[OFS_W-1:0], snoopAddr[OFS_W-1:0], evictAddr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockTag <= '0;
    end else if (strobe.loadTag) begin
      lockTag <= reqAddr[ADDR_W-1:OFS_W];
    end
  end

  // Probe 0: invalidation, 1: read-for-ownership, 2: eviction.
  assign probeAddr[0]  = snoopAddr;
  assign probeValid[0] = snoopInv;
  assign probeAddr[1]  = snoopAddr;
  assign probeValid[1] = snoopRdx;
  assign probeAddr[2]  = evictAddr;
  assign probeValid[2] = evictValid;

  for (genvar i = 0; i < NUM_PROBES; i++) begin : g_probe
    assign hitVec[i] = probeValid[i] && strobe.compareEn &&
                       (probeAddr[i][ADDR_W-1:OFS_W] == lockTag);
  end

  assign hits.invHit   = hitVec[0];
  assign hits.rdxHit   = hitVec[1];
  assign hits.evictHit = hitVec[2];

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        llValid,
  input  logic        scValid,
  input  resvHit_t    hits,
  output resvStrobe_t strobe,
  output logic        storeGrant,
  output logic        scDone,
  output logic        scPass,
  output logic        resvFlag
);

  resvState_t state, stateNext;
  logic       breakNow;

  assign breakNow = hits.invHit || hits.rdxHit || hits.evictHit;

  assign strobe.loadTag   = llValid;
  assign strobe.compareEn = (state == RESV_ARMED);

  // A same-cycle breaking event wins over the store-conditional.
  assign storeGrant = scValid && (state == RESV_ARMED) && !breakNow;

  always_comb begin
    stateNext = state;
    if (llValid) begin
      stateNext = RESV_ARMED;
    end else if (scValid || breakNow) begin
      stateNext = RESV_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RESV_IDLE;
      scDone <= 1'b0;
      scPass <= 1'b0;
    end else begin
      state  <= stateNext;
      scDone <= scValid;
      scPass <= storeGrant;
    end
  end

  assign resvFlag = (state == RESV_ARMED);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snoopInv,
  input  logic              snoopRdx,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  output logic              storeGrant,
  output logic              scDone,
  output logic              scPass
);

  resvStrobe_t strobe;
  resvHit_t    hits;
  logic        resvFlag;

  resv_datapath #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .snoopInv   (snoopInv),
    .snoopRdx   (snoopRdx),
    .snoopAddr  (snoopAddr),
    .evictValid (evictValid),
    .evictAddr  (evictAddr),
    .hits       (hits)
  );

  resv_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .llValid    (llValid),
    .scValid    (scValid),
    .hits       (hits),
    .strobe     (strobe),
    .storeGrant (storeGrant),
    .scDone     (scDone),
    .scPass     (scPass),
    .resvFlag   (resvFlag)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic llValid,
  input logic scValid,
  input logic storeGrant,
  input logic scDone,
  input logic scPass,
  input logic resvFlag
);

  // R2: a granted store is reported as a pass next cycle
  p_grant_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeGrant |=> (scDone && scPass));

  // R3: an ungranted store-conditional is reported as a failure
  p_nogrant_fail_r3: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !storeGrant) |=> (scDone && !scPass));

  // R8: store-conditional always disarms
  p_sc_disarms_r8: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !llValid) |=> !resvFlag);

  // R11: load-linked always arms, even with a same-cycle snoop
  p_ll_arms_r11: assert property (@(posedge clk) disable iff (!rstN)
    llValid |=> resvFlag);

  // R12: no outcome without a request
  p_done_only_after_sc_r12: assert property (@(posedge clk) disable iff (!rstN)
    !scValid |=> !scDone);

  // R2: grant only for a store-conditional while armed
  p_grant_needs_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeGrant |-> (scValid && resvFlag));

endmodule

bind resv_monitor resv_monitor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .llValid    (llValid),
  .scValid    (scValid),
  .storeGrant (storeGrant),
  .scDone     (scDone),
  .scPass     (scPass),
  .resvFlag   (resvFlag)
);

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

  localparam int unsigned ADDR_W = 32;
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_LL   = 2'd1;
  localparam logic [1:0] OP_SC   = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        inv;
    logic        rdx;
    logic        ev;
    logic [31:0] sAddr;
    logic        expGrant;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{OP_SC,   32'h0000_0100, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd3},  // R3 no reservation
    '{OP_LL,   32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd2},
    '{OP_SC,   32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 8'd2},  // R2 clean pair
    '{OP_SC,   32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd8},  // R8 second SC
    '{OP_LL,   32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd4},
    '{OP_NONE, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0000_203C, 1'b0, 8'd4},
    '{OP_SC,   32'h0000_2000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd4},  // R4 inv same block
    '{OP_LL,   32'h0000_3000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd5},
    '{OP_NONE, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_3004, 1'b0, 8'd5},
    '{OP_SC,   32'h0000_3000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd5},  // R5 rdx same block
    '{OP_LL,   32'h0000_4000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd6},
    '{OP_NONE, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0000_4040, 1'b0, 8'd6},
    '{OP_NONE, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_5000, 1'b0, 8'd6},
    '{OP_SC,   32'h0000_4000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 8'd6},  // R6 other blocks
    '{OP_LL,   32'h0000_6000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd7},
    '{OP_NONE, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0000_6010, 1'b0, 8'd7},
    '{OP_SC,   32'h0000_6000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd7},  // R7 evict same block
    '{OP_LL,   32'h0000_7000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd7},
    '{OP_NONE, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0000_7080, 1'b0, 8'd7},
    '{OP_SC,   32'h0000_7000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 8'd7},  // R7 evict other
    '{OP_LL,   32'h0000_8000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd9},
    '{OP_SC,   32'h0000_8000, 1'b1, 1'b0, 1'b0, 32'h0000_8020, 1'b0, 8'd9},  // R9 same-cycle kill
    '{OP_LL,   32'h0000_9000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd10},
    '{OP_LL,   32'h0000_A000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd10},
    '{OP_NONE, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0000_9000, 1'b0, 8'd10},
    '{OP_SC,   32'h0000_A000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 8'd10}, // R10 old block ignored
    '{OP_LL,   32'h0000_B000, 1'b1, 1'b0, 1'b0, 32'h0000_B000, 1'b0, 8'd11},
    '{OP_SC,   32'h0000_B000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 8'd11}, // R11 LL wins
    '{OP_LL,   32'h0000_C000, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd9},
    '{OP_SC,   32'h0000_C000, 1'b0, 1'b1, 1'b1, 32'h0000_D000, 1'b1, 8'd9},  // R9 other-block snoop
    '{OP_NONE, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 8'd12}  // R12 idle
  };

  logic clk = 1'b0;
  logic rstN;
  logic llValid, scValid, snoopInv, snoopRdx, evictValid;
  logic [ADDR_W-1:0] reqAddr, snoopAddr, evictAddr;
  logic storeGrant, scDone, scPass;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  resv_monitor #(.ADDR_W(ADDR_W), .BLOCK_BYTES(64)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .llValid    (llValid),
    .scValid    (scValid),
    .reqAddr    (reqAddr),
    .snoopInv   (snoopInv),
    .snoopRdx   (snoopRdx),
    .snoopAddr  (snoopAddr),
    .evictValid (evictValid),
    .evictAddr  (evictAddr),
    .storeGrant (storeGrant),
    .scDone     (scDone),
    .scPass     (scPass)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idleInputs();
    llValid = 0; scValid = 0; snoopInv = 0; snoopRdx = 0; evictValid = 0;
    reqAddr = '0; snoopAddr = '0; evictAddr = '0;
  endtask

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    scValid = 1'b1;
    #1;
    check("R1 grant in reset", int'(storeGrant), 0);
    @(posedge clk); #1;
    check("R1 scDone in reset", int'(scDone), 0);
    check("R1 scPass in reset", int'(scPass), 0);
    @(negedge clk);
    idleInputs();
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idleInputs();
      llValid    = (VECS[i].op == OP_LL);
      scValid    = (VECS[i].op == OP_SC);
      reqAddr    = VECS[i].addr;
      snoopInv   = VECS[i].inv;
      snoopRdx   = VECS[i].rdx;
      evictValid = VECS[i].ev;
      snoopAddr  = VECS[i].sAddr;
      evictAddr  = VECS[i].sAddr;
      #1;
      check($sformatf("R%0d grant vec %0d", VECS[i].rq, i), int'(storeGrant), int'(VECS[i].expGrant));
      @(posedge clk); #1;
      check($sformatf("R12 scDone vec %0d", i), int'(scDone), int'(VECS[i].op == OP_SC));
      if (VECS[i].op == OP_SC)
        check($sformatf("R%0d scPass vec %0d", VECS[i].rq, i), int'(scPass), int'(VECS[i].expGrant));
    end

    // R1: reset mid-run drops an armed reservation
    @(negedge clk);
    idleInputs();
    llValid = 1'b1; reqAddr = 32'h0000_E000;
    @(negedge clk);
    idleInputs();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    scValid = 1'b1; reqAddr = 32'h0000_E000;
    #1;
    check("R1 grant after reset", int'(storeGrant), 0);
    @(posedge clk); #1;
    check("R1 scDone after reset", int'(scDone), 1);
    check("R1 scPass after reset", int'(scPass), 0);
    @(negedge clk);
    idleInputs();
    @(posedge clk); #1;
    check("R12 scDone idle", int'(scDone), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule